// File: doc/BRIEF.md
# Quad-Output Serial Flash Burst Reader

This block is a host-side master that fetches a run of consecutive bytes from a serial NOR flash using the quad-output fast read operation. A client places a 24-bit start address and a byte count on a single-cycle request port. While a request is in progress the block owns the flash bus. It lowers chip select and sends the opcode and the address one bit per clock on data line 0. It then releases every data line, runs the fixed dummy clocks, and collects one nibble per clock from all four lines.

The serial clock runs at a fixed number of system-clock cycles per half period. The block samples on the rising serial-clock edge and changes its own outputs on the falling edge. Its idle level is chosen by a static input, so flashes wired for either clock polarity can be used. Each completed byte is offered on a valid/ready stream. If the consumer holds back, the serial clock is parked high at the next byte boundary, and no byte is dropped or overwritten.

Top module: `qspi_burst_reader`

## Requirements
- R1: The first 8 serial clocks of a frame carry the opcode 0x6B on io_out[0], most significant bit first, with io_oe = 4'b0001; each bit is stable across its rising edge.
- R2: Serial clocks 8 to 31 carry the 24-bit request address on io_out[0], most significant bit first.
- R3: Clocks 32 to 39 are dummy clocks. io_oe[0] falls at the falling edge that ends clock 31 and stays low to the end of the frame. io_oe[3:1] is never set, and io_oe is zero while cs_n is high.
- R4: From clock 40 on, io_in is sampled at each rising serial-clock edge, with io_in[3] as the most significant bit of the nibble. The first nibble of a byte supplies bits 7:4 and the second supplies bits 3:0, and the byte is presented on m_data.
- R5: A frame contains exactly 40 + 2*req_len rising edges and returns req_len bytes in address order. cs_n rises at the end of the high phase of the last clock.
- R6: With cpol = 0 the serial clock idles low, and with cpol = 1 it idles high. sck equals cpol whenever cs_n is high, and in both settings sampling happens on the rising edge.
- R7: cs_n falls exactly one serial-clock period (2*HALF_CYC system clocks) before the first rising edge of the frame.
- R8: busy rises in the cycle after a request is accepted and stays high until cs_n has been high for one full serial-clock period. A request presented while busy is high is ignored, and cs_n is low only while busy is high.
- R9: A request with req_len = 0 is ignored: busy stays low and no frame starts.
- R10: While m_valid is high and m_ready is low, m_data and m_valid hold. The serial clock pauses at the byte boundary, so every byte is delivered intact under any m_ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpol | input | 1 | Serial clock idle level (0 low, 1 high); change only while idle |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Request in progress; new requests refused |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low flash chip select |
| io_out | output | 4 | Values driven on the four data lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values read from the four data lines |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_ready | input | 1 | Consumer ready for the output byte |

## Verification
The bench models the flash from the pins. It shifts in the header on rising edges and drives nibbles on falling edges from an address-derived pattern. It sweeps both clock polarities, several lengths and addresses that include the top of the address space, with and without heavy back-pressure. Several faults are targeted. An off-by-one in the dummy count shifts every nibble and corrupts all bytes. A reversed nibble order swaps the byte halves. A late release of io_oe shows up at the first dummy rising edge. A missing stall overwrites a byte that has not been taken. The bench also issues two requests back to back to catch a chip-select gap that is too short, and it sends a request during a frame to catch a second frame starting.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_SETUP = 3'd1,
    SQ_LOW   = 3'd2,
    SQ_HIGH  = 3'd3,
    SQ_GAP0  = 3'd4,
    SQ_GAP1  = 3'd5
  } seq_state_e;

  localparam logic [7:0] QUAD_READ_OP = 8'h6B;
  localparam int OP_BITS = 8;
endpackage

// File: rtl/qspi_half_timer.sv
module qspi_half_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic half_end
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = CW'(HALF_CYC - 1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign half_end = (cnt_q == '0);
endmodule

// File: rtl/qspi_frame_seq.sv
module qspi_frame_seq
  import qspi_rd_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 8,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              half_end,
  input  logic              stall,
  output logic              timer_load,
  output seq_state_e        state,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              take_hi,
  output logic              take_lo
);
  localparam int HDR_W = OP_BITS + ADDR_W;
  localparam int HDR   = HDR_W + DUMMY_CLKS;
  localparam int KW    = $clog2(HDR + 1);

  seq_state_e       st_q, st_d;
  logic [KW-1:0]    k_q, k_d;
  logic             nib_q, nib_d;
  logic [HDR_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             in_data, byte_next;

  assign in_data   = (k_q == KW'(HDR));
  assign byte_next = (k_q == KW'(HDR - 1)) || (in_data && nib_q);

  always_comb begin
    st_d       = st_q;
    k_d        = k_q;
    nib_d      = nib_q;
    sh_d       = sh_q;
    left_d     = left_q;
    timer_load = 1'b0;
    take_hi    = 1'b0;
    take_lo    = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (req_valid && (req_len != '0)) begin
          st_d       = SQ_SETUP;
          sh_d       = {QUAD_READ_OP, req_addr};
          left_d     = req_len;
          k_d        = '0;
          nib_d      = 1'b0;
          timer_load = 1'b1;
        end
      end
      SQ_SETUP: begin
        if (half_end) begin
          st_d       = SQ_LOW;
          timer_load = 1'b1;
        end
      end
      SQ_LOW: begin
        if (half_end) begin
          st_d       = SQ_HIGH;
          timer_load = 1'b1;
          if (in_data) begin
            if (!nib_q) begin
              take_hi = 1'b1;
            end else begin
              take_lo = 1'b1;
              left_d  = left_q - LEN_W'(1);
            end
          end
        end
      end
      SQ_HIGH: begin
        if (half_end) begin
          if (in_data && nib_q && (left_q == '0)) begin
            st_d       = SQ_GAP0;
            timer_load = 1'b1;
          end else if (!(byte_next && stall)) begin
            st_d       = SQ_LOW;
            timer_load = 1'b1;
            sh_d       = {sh_q[HDR_W-2:0], 1'b0};
            if (in_data) nib_d = ~nib_q;
            else         k_d   = k_q + KW'(1);
          end
        end
      end
      SQ_GAP0: begin
        if (half_end) begin
          st_d       = SQ_GAP1;
          timer_load = 1'b1;
        end
      end
      SQ_GAP1: begin
        if (half_end) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      k_q    <= '0;
      nib_q  <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      k_q    <= k_d;
      nib_q  <= nib_d;
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign state   = st_q;
  assign io0_out = sh_q[HDR_W-1];
  assign io0_oe  = ((st_q == SQ_SETUP) || (st_q == SQ_LOW) || (st_q == SQ_HIGH))
                   && (k_q < KW'(HDR_W));
endmodule

// File: rtl/qspi_nibble_pack.sv
module qspi_nibble_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] io_in,
  input  logic       take_hi,
  input  logic       take_lo,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       stall
);
  logic [3:0] hi_q, hi_d;
  logic [7:0] data_q, data_d;
  logic       vld_q, vld_d;

  always_comb begin
    hi_d   = take_hi ? io_in : hi_q;
    data_d = take_lo ? {hi_q, io_in} : data_q;
    vld_d  = take_lo ? 1'b1 : (vld_q && !m_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign m_valid = vld_q;
  assign m_data  = data_q;
  assign stall   = vld_q && !m_ready;
endmodule

// File: rtl/qspi_burst_reader.sv
module qspi_burst_reader
  import qspi_rd_pkg::*;
#(
  parameter int HALF_CYC   = 2,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 8,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in,
  output logic              m_valid,
  output logic [7:0]        m_data,
  input  logic              m_ready
);
  seq_state_e state;
  logic half_end, timer_load, stall;
  logic io0_out, io0_oe, take_hi, take_lo;

  qspi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .half_end(half_end)
  );

  qspi_frame_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DUMMY_CLKS(DUMMY_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .half_end(half_end), .stall(stall), .timer_load(timer_load),
    .state(state), .io0_out(io0_out), .io0_oe(io0_oe),
    .take_hi(take_hi), .take_lo(take_lo)
  );

  qspi_nibble_pack u_pack (
    .clk(clk), .rst_n(rst_n), .io_in(io_in),
    .take_hi(take_hi), .take_lo(take_lo), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .stall(stall)
  );

  always_comb begin
    case (state)
      SQ_LOW:  sck = 1'b0;
      SQ_HIGH: sck = 1'b1;
      default: sck = cpol;
    endcase
  end

  assign cs_n   = !((state == SQ_SETUP) || (state == SQ_LOW) || (state == SQ_HIGH));
  assign busy   = (state != SQ_IDLE);
  assign io_out = {3'b000, io0_out};
  assign io_oe  = {3'b000, io0_oe};
endmodule

// File: rtl/qspi_rd_checker.sv
module qspi_rd_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpol,
  input logic             req_valid,
  input logic [LEN_W-1:0] req_len,
  input logic             busy,
  input logic             sck,
  input logic             cs_n,
  input logic [3:0]       io_oe,
  input logic             m_valid,
  input logic [7:0]       m_data,
  input logic             m_ready
);
  AST_SIDE_LINES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe[3:1] == 3'b000);  // R3
  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));  // R3
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == cpol));  // R6
  AST_SELECT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);  // R8
  AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && (req_len == '0)) |=> !busy);  // R9
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));  // R10
endmodule

bind qspi_burst_reader qspi_rd_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .req_valid(req_valid),
  .req_len(req_len), .busy(busy), .sck(sck), .cs_n(cs_n), .io_oe(io_oe),
  .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
);

// File: tb/sim_qspi_burst_reader.sv
`timescale 1ns/1ps
module sim_qspi_burst_reader;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst_n, cpol, req_valid, m_ready;
  logic [23:0] req_addr;
  logic [7:0]  req_len;
  logic [3:0]  io_in;
  wire         busy, sck, cs_n, m_valid;
  wire  [3:0]  io_out, io_oe;
  wire  [7:0]  m_data;

  always #4 clk = ~clk;

  qspi_burst_reader #(.HALF_CYC(H), .ADDR_W(24), .LEN_W(8), .DUMMY_CLKS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .req_valid(req_valid),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .sck(sck),
    .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
  );

  int checks = 0;
  int errors = 0;

  // flash model and pin monitor state
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  int          rises = 0, setup_cnt = 0, setup_meas = 0, gap_cnt = 1000, last_gap = 1000;
  int          frame_cnt = 0, oe_bad = 0, idle_bad = 0;
  logic        seen_rise = 1'b0;
  logic [31:0] hdr = '0;

  // stream sink state
  logic        bp_on = 1'b0, prev_stall = 1'b0;
  logic [7:0]  prev_md = '0;
  logic [31:0] cyc = '0;
  logic [7:0]  rx [16];
  int          rx_n = 0, hold_bad = 0;

  function automatic logic [7:0] dat(input logic [23:0] a);
    dat = a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic rising, falling;
      rising  = !prev_sck && sck;
      falling = prev_sck && !sck;
      if (!prev_cs && cs_n) gap_cnt = 0;
      if (prev_cs && !cs_n) begin
        frame_cnt++;
        last_gap = gap_cnt;
        rises = 0; seen_rise = 1'b0; setup_cnt = 0; hdr = '0;
      end
      if (cs_n) begin
        gap_cnt++;
        if (sck !== cpol) idle_bad++;
        if (io_oe != 4'b0000) oe_bad++;
      end else begin
        if (!seen_rise && !rising) setup_cnt++;
        if (rising) begin
          if (!seen_rise) begin seen_rise = 1'b1; setup_meas = setup_cnt; end
          if (rises < 32) begin
            hdr = {hdr[30:0], io_out[0]};
            if (io_oe != 4'b0001) oe_bad++;
          end else if (io_oe != 4'b0000) oe_bad++;
          rises++;
        end else if (falling && rises >= 40) begin
          int n;
          logic [7:0] b;
          n = rises - 40;
          b = dat(hdr[23:0] + 24'(n / 2));
          io_in = (n % 2 == 0) ? b[7:4] : b[3:0];
          if (rises >= 32 && io_oe != 4'b0000) oe_bad++;
        end
      end
      prev_sck = sck;
      prev_cs  = cs_n;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    m_ready = bp_on ? (cyc[3:0] >= 4'd12) : 1'b1;
    if (rst_n) begin
      if (prev_stall && (!m_valid || m_data !== prev_md)) hold_bad++;
      if (m_valid && m_ready) begin
        if (rx_n < 16) rx[rx_n] = m_data;
        rx_n++;
      end
      prev_stall = m_valid && !m_ready;
      prev_md    = m_data;
    end
  end

  task automatic run_txn(input bit mode, input logic [23:0] a, input logic [7:0] len,
                         input bit bp, input bit drain);
    int fc0;
    @(negedge clk);
    cpol = mode; bp_on = bp;
    rx_n = 0; oe_bad = 0; idle_bad = 0; hold_bad = 0;
    fc0 = frame_cnt;
    req_valid = 1'b1; req_addr = a; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 1);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_addr = ~a; req_len = 8'd3;   // R8 request while busy
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    if (drain) begin
      repeat (24) @(negedge clk);
      chk(cs_n == 1'b1 && busy == 1'b0, "R8 ignored request started nothing", {cs_n, busy}, 2);
    end
    chk(frame_cnt == fc0 + 1, "R8 one frame per request", frame_cnt - fc0, 1);
    chk(last_gap >= 2 * H, "R8 chip select gap", last_gap, 2 * H);
    chk(hdr[31:24] == 8'h6B, "R1 opcode", hdr[31:24], 8'h6B);
    chk(hdr[23:0] == a, "R2 address", hdr[23:0], a);
    chk(oe_bad == 0, "R3 output enable", oe_bad, 0);
    chk(rises == 40 + 2 * len, "R5 rising edges", rises, 40 + 2 * len);
    chk(setup_meas == 2 * H, "R7 select setup", setup_meas, 2 * H);
    chk(idle_bad == 0, "R6 idle level", idle_bad, 0);
    if (drain) begin
      chk(rx_n == int'(len), "R5 byte count", rx_n, len);
      for (int i = 0; i < int'(len) && i < 16; i++)
        chk(rx[i] == dat(a + 24'(i)), "R4 byte value", rx[i], dat(a + 24'(i)));
      if (bp) chk(hold_bad == 0, "R10 hold under back-pressure", hold_bad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  lens [4];
    logic [23:0] addrs [3];
    lens  = '{8'd1, 8'd2, 8'd3, 8'd5};
    addrs = '{24'h000000, 24'hA5C3F0, 24'hFFFFFE};
    rst_n = 1'b0; cpol = 1'b1; req_valid = 1'b0; req_addr = '0; req_len = '0;
    io_in = '0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && m_valid == 1'b0, "R8 reset state", {cs_n, busy, m_valid}, 4);
    chk(io_oe == 4'b0000, "R3 reset output enable", io_oe, 0);
    chk(sck == 1'b1, "R6 reset idle level", sck, 1);
    rst_n = 1'b1;
    prev_sck = sck;
    repeat (2) @(negedge clk);

    // R9: zero-length request
    req_valid = 1'b1; req_addr = 24'h00ABCD; req_len = 8'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0, "R9 zero length refused", busy, 0);
    repeat (8) @(negedge clk);
    chk(cs_n == 1'b1 && frame_cnt == 0, "R9 no frame for zero length", frame_cnt, 0);

    for (int m = 0; m < 2; m++)
      for (int li = 0; li < 4; li++)
        for (int ai = 0; ai < 3; ai++)
          for (int bp = 0; bp < 2; bp++)
            run_txn(m[0], addrs[ai], lens[li], bp[0], 1'b1);

    // back-to-back requests: R8 gap, R6 polarity switch in idle
    run_txn(1'b0, 24'h123456, 8'd2, 1'b0, 1'b0);
    run_txn(1'b1, 24'h654321, 8'd2, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule